// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block maps device addresses that land inside a fixed window (the aperture) onto physical memory, with a granularity of 4 KiB pages. Each page of the aperture owns one 32-bit slot in an on-chip table. Bit 31 of a slot marks it as mapped. Bits 30:12 carry the physical page frame. A lookup port takes a device address. One clock later it returns either a hit with the translated address or a fault.

Software fills the table through a small register window. A configuration register turns translation on or off. A selector register takes a full aperture byte address, and that address picks a table slot. A data register then writes or reads the picked slot. Reading back the configuration register is the software's way to confirm that earlier writes have landed. The aperture base and the page count are build parameters.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, every table slot reads as zero, and the lookup outputs and register read data are all zero.
- R2: A write to offset 0x24 sets the translation enable from write data bit 0. A read of 0x24 returns the enable in bit 0 with zeros above it. The read data appears one clock after the read cycle.
- R3: A write to offset 0x28 stores the full 32-bit write data as the selected address. A read of 0x28 returns it.
- R4: While the selected address lies inside the aperture, a write to offset 0x2C stores all 32 bits in slot (selected − base) >> 12. A read of 0x2C returns that slot.
- R5: While the selected address lies outside the aperture, writes to 0x2C change no slot, and reads of 0x2C return zero.
- R6: An address is inside the aperture when it is at or above the base and below base + page count × 4096. A lookup outside that range faults.
- R7: A lookup that meets all three conditions hits: translation is enabled, the address is inside the aperture, and the slot has bit 31 set. For a hit, on the next clock xlatHit is 1, xlatFault is 0, and xlatPhys is {0, slot[30:12], address[11:0]}.
- R8: A lookup faults when it reaches a slot with bit 31 clear, or when translation is disabled. On the next clock xlatFault is 1, xlatHit is 0, and xlatPhys is zero.
- R9: A clock with no lookup request leaves xlatHit, xlatFault and xlatPhys at zero on the next clock.
- R10: Writing an all-zero word into a slot unmaps that page. Later lookups to the page fault.
- R11: Accesses to any other offset change no state. Reads of such an offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regEn | input | 1 | Register access valid this cycle |
| regWe | input | 1 | 1 = write, 0 = read |
| regOffset | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid the clock after a read |
| xlatReq | input | 1 | Lookup request |
| xlatAddr | input | 32 | Device address to translate |
| xlatHit | output | 1 | Lookup hit, one clock after the request |
| xlatFault | output | 1 | Lookup fault, one clock after the request |
| xlatPhys | output | 32 | Translated address on a hit, zero otherwise |

## Verification
Register read data and lookup results both appear at the first rising edge after the request cycle. Because the bench drives every access on a falling edge and samples at the following falling edge, each result is read in the half cycle right after the edge that produced it. The idle cycle after each lookup is sampled the same way, which shows the outputs drop back to zero. The sweep covers every page of a 16-page aperture at several in-page offsets, with translation both off and on, and probes addresses on both sides of each aperture limit.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam logic [7:0] OFF_CFG   = 8'h24;
  localparam logic [7:0] OFF_SEL   = 8'h28;
  localparam logic [7:0] OFF_ENTRY = 8'h2C;
  localparam int         PAGE_SHIFT = 12;

  // Strobes from register decode to the table datapath
  typedef struct packed {
    logic selWr;
    logic entryWr;
    logic rdAny;
    logic rdCfg;
    logic rdSel;
    logic rdEntry;
  } regStrobes_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regEn,
  input  logic        regWe,
  input  logic [7:0]  regOffset,
  input  logic        cfgBit,
  output regStrobes_t stb,
  output logic        xlatEn
);
  logic cfgWr;

  always_comb begin
    cfgWr       = regEn && regWe && (regOffset == OFF_CFG);
    stb.selWr   = regEn && regWe && (regOffset == OFF_SEL);
    stb.entryWr = regEn && regWe && (regOffset == OFF_ENTRY);
    stb.rdAny   = regEn && !regWe;
    stb.rdCfg   = regOffset == OFF_CFG;
    stb.rdSel   = regOffset == OFF_SEL;
    stb.rdEntry = regOffset == OFF_ENTRY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      xlatEn <= 1'b0;
    else if (cfgWr) xlatEn <= cfgBit;
  end
endmodule

// File: rtl/remap_table.sv
module remap_table
  import remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h4000_0000,
  parameter int          PAGE_COUNT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStrobes_t stb,
  input  logic        xlatEn,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        xlatReq,
  input  logic [31:0] xlatAddr,
  output logic        xlatHit,
  output logic        xlatFault,
  output logic [31:0] xlatPhys
);
  localparam int          IDX_W   = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;
  localparam logic [32:0] APER_LO = {1'b0, APER_BASE};
  localparam logic [32:0] APER_HI = APER_LO + 33'(PAGE_COUNT) * 33'd4096;
  localparam logic [31:0] FRAME_MASK = 32'h7FFF_F000;

  function automatic logic inAper(input logic [31:0] a);
    return ({1'b0, a} >= APER_LO) && ({1'b0, a} < APER_HI);
  endfunction

  function automatic logic [IDX_W-1:0] idxOf(input logic [31:0] a);
    return IDX_W'((a - APER_BASE) >> PAGE_SHIFT);
  endfunction

  logic [31:0]      selAddr;
  logic             selIn;
  logic [IDX_W-1:0] selIdx;
  logic [31:0]      view [PAGE_COUNT];

  assign selIn  = inAper(selAddr);
  assign selIdx = idxOf(selAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          selAddr <= '0;
    else if (stb.selWr) selAddr <= wdata;
  end

  // One register per page slot
  for (genvar g = 0; g < PAGE_COUNT; g++) begin : gSlot
    logic [31:0] slot;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slot <= '0;
      else if (stb.entryWr && selIn && (selIdx == IDX_W'(g)))
        slot <= wdata;
    end
    assign view[g] = slot;
  end

  // Register read path, one clock of latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdata <= '0;
    else if (stb.rdAny) begin
      if (stb.rdCfg)        rdata <= {31'b0, xlatEn};
      else if (stb.rdSel)   rdata <= selAddr;
      else if (stb.rdEntry) rdata <= selIn ? view[selIdx] : '0;
      else                  rdata <= '0;
    end
  end

  // Lookup path
  logic        lkIn;
  logic [31:0] lkEntry;
  logic        hitNext;

  assign lkIn    = inAper(xlatAddr);
  assign lkEntry = lkIn ? view[idxOf(xlatAddr)] : '0;
  assign hitNext = xlatReq && xlatEn && lkIn && lkEntry[31];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xlatHit   <= 1'b0;
      xlatFault <= 1'b0;
      xlatPhys  <= '0;
    end else begin
      xlatHit   <= hitNext;
      xlatFault <= xlatReq && !hitNext;
      xlatPhys  <= hitNext ? ((lkEntry & FRAME_MASK) | {20'b0, xlatAddr[11:0]}) : '0;
    end
  end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h4000_0000,
  parameter int          PAGE_COUNT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regEn,
  input  logic        regWe,
  input  logic [7:0]  regOffset,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        xlatReq,
  input  logic [31:0] xlatAddr,
  output logic        xlatHit,
  output logic        xlatFault,
  output logic [31:0] xlatPhys
);
  regStrobes_t stb;
  logic        xlatEn;

  remap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe),
    .regOffset(regOffset), .cfgBit(regWdata[0]), .stb(stb), .xlatEn(xlatEn)
  );

  remap_table #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT)) u_table (
    .clk(clk), .rstN(rstN), .stb(stb), .xlatEn(xlatEn), .wdata(regWdata),
    .rdata(regRdata), .xlatReq(xlatReq), .xlatAddr(xlatAddr),
    .xlatHit(xlatHit), .xlatFault(xlatFault), .xlatPhys(xlatPhys)
  );
endmodule

// File: rtl/remap_checker.sv
module remap_checker
  import remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h4000_0000,
  parameter int          PAGE_COUNT = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        regEn,
  input logic        regWe,
  input logic [7:0]  regOffset,
  input logic [31:0] regRdata,
  input logic        xlatEn,
  input logic        xlatReq,
  input logic [31:0] xlatAddr,
  input logic        xlatHit,
  input logic        xlatFault,
  input logic [31:0] xlatPhys
);
  localparam logic [32:0] LO = {1'b0, APER_BASE};
  localparam logic [32:0] HI = LO + 33'(PAGE_COUNT) * 33'd4096;

  logic outside;
  logic otherRead;
  assign outside   = ({1'b0, xlatAddr} < LO) || ({1'b0, xlatAddr} >= HI);
  assign otherRead = regEn && !regWe && (regOffset != OFF_CFG) &&
                     (regOffset != OFF_SEL) && (regOffset != OFF_ENTRY);

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && !regWe && regOffset == OFF_CFG) |=> regRdata == {31'b0, $past(xlatEn)}); // R2
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    xlatReq |=> (xlatHit != xlatFault)); // R7
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    xlatHit |-> (xlatPhys[11:0] == $past(xlatAddr[11:0])) && !xlatPhys[31]); // R7
  AST_DISABLED_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (xlatReq && !xlatEn) |=> xlatFault && xlatPhys == '0); // R8
  AST_OUTSIDE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (xlatReq && outside) |=> xlatFault && xlatPhys == '0); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !xlatReq |=> !xlatHit && !xlatFault && xlatPhys == '0); // R9
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    otherRead |=> regRdata == '0); // R11
endmodule

bind aperture_remap remap_checker #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT)) u_chk (
  .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe), .regOffset(regOffset),
  .regRdata(regRdata), .xlatEn(xlatEn), .xlatReq(xlatReq), .xlatAddr(xlatAddr),
  .xlatHit(xlatHit), .xlatFault(xlatFault), .xlatPhys(xlatPhys)
);

// File: tb/test_aperture_remap.sv
module test_aperture_remap;
  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam int          PAGES = 16;
  localparam logic [31:0] TOP   = BASE + PAGES * 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regEn = 1'b0, regWe = 1'b0;
  logic [7:0]  regOffset = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        xlatReq = 1'b0;
  logic [31:0] xlatAddr = '0, xlatPhys;
  logic        xlatHit, xlatFault;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [31:0] expTbl [PAGES];

  always #5 clk = ~clk;

  aperture_remap #(.APER_BASE(BASE), .PAGE_COUNT(PAGES)) i_aperture_remap (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe), .regOffset(regOffset),
    .regWdata(regWdata), .regRdata(regRdata), .xlatReq(xlatReq), .xlatAddr(xlatAddr),
    .xlatHit(xlatHit), .xlatFault(xlatFault), .xlatPhys(xlatPhys)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    regEn = 1'b1; regWe = 1'b1; regOffset = off; regWdata = d;
    @(negedge clk);
    regEn = 1'b0; regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    regEn = 1'b1; regWe = 1'b0; regOffset = off;
    @(negedge clk);
    regEn = 1'b0;
    d = regRdata;
  endtask

  // Lookup; result sampled one falling edge later, then idle cycle checked
  task automatic lookup(input string req, input logic [31:0] a, input bit expHit,
                        input logic [31:0] expPhys);
    @(negedge clk);
    xlatReq = 1'b1; xlatAddr = a;
    @(negedge clk);
    xlatReq = 1'b0;
    check(req, {31'b0, xlatHit}, {31'b0, expHit});
    check(req, {31'b0, xlatFault}, {31'b0, !expHit});
    check(req, xlatPhys, expPhys);
    @(negedge clk);
    check("R9", {xlatPhys[31:2], xlatHit, xlatFault}, 32'h0);
  endtask

  function automatic logic [31:0] physOf(input logic [31:0] e, input logic [31:0] a);
    return (e & 32'h7FFF_F000) | (a & 32'h0000_0FFF);
  endfunction

  initial begin
    logic [31:0] d;
    for (int i = 0; i < PAGES; i++)
      expTbl[i] = ((i % 2 == 0) ? 32'h8000_0000 : 32'h0) |
                  ((i >= 8) ? 32'h4000_0000 : 32'h0) |
                  (32'(i * 37 + 5) << 12) | 32'(i * 3);

    repeat (3) @(negedge clk);
    check("R1", {regRdata[31:2], xlatHit, xlatFault}, 32'h0);
    check("R1", xlatPhys, 32'h0);
    rstN = 1'b1;
    regRead(8'h24, d); check("R1", d, 32'h0);
    for (int i = 0; i < PAGES; i++) begin
      regWrite(8'h28, BASE + 32'(i) * 4096);
      regRead(8'h2C, d); check("R1", d, 32'h0);
    end

    // R3 selector readback
    regWrite(8'h28, 32'hDEAD_BEEF);
    regRead(8'h28, d); check("R3", d, 32'hDEAD_BEEF);

    // R4 fill and read back every slot, selecting with in-page offsets
    for (int i = 0; i < PAGES; i++) begin
      regWrite(8'h28, BASE + 32'(i) * 4096 + 32'(i * 16));
      regWrite(8'h2C, expTbl[i]);
    end
    for (int i = 0; i < PAGES; i++) begin
      regWrite(8'h28, BASE + 32'(i) * 4096 + 32'hFFC);
      regRead(8'h2C, d); check("R4", d, expTbl[i]);
    end

    // R8 translation disabled: valid page still faults
    lookup("R8", BASE + 32'h123, 1'b0, 32'h0);

    // R2 enable and read back
    regWrite(8'h24, 32'h1);
    regRead(8'h24, d); check("R2", d, 32'h1);

    // R7 and R8 sweep over every page and several offsets
    for (int i = 0; i < PAGES; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        a = BASE + 32'(i) * 4096 +
            ((k == 0) ? 32'h0 : (k == 1) ? 32'h7FF : (k == 2) ? 32'hFFF : 32'(i * 273));
        if (expTbl[i][31]) lookup("R7", a, 1'b1, physOf(expTbl[i], a));
        else               lookup("R8", a, 1'b0, 32'h0);
      end
    end

    // R6 aperture edges
    lookup("R6", BASE - 1, 1'b0, 32'h0);
    lookup("R6", BASE - 4096, 1'b0, 32'h0);
    lookup("R6", TOP, 1'b0, 32'h0);
    lookup("R6", 32'h0, 1'b0, 32'h0);
    lookup("R6", BASE, 1'b1, physOf(expTbl[0], BASE));
    if (expTbl[PAGES-1][31]) lookup("R6", TOP - 1, 1'b1, physOf(expTbl[PAGES-1], TOP - 1));
    else                     lookup("R6", TOP - 1, 1'b0, 32'h0);

    // R5 selector outside aperture
    regWrite(8'h28, TOP);
    regWrite(8'h2C, 32'hFFFF_FFFF);
    regRead(8'h2C, d); check("R5", d, 32'h0);
    regWrite(8'h28, BASE - 4);
    regWrite(8'h2C, 32'hFFFF_FFFF);
    regRead(8'h2C, d); check("R5", d, 32'h0);
    for (int i = 0; i < PAGES; i++) begin
      regWrite(8'h28, BASE + 32'(i) * 4096);
      regRead(8'h2C, d); check("R5", d, expTbl[i]);
    end

    // R11 other offsets
    regWrite(8'h20, 32'h0);
    regWrite(8'h30, 32'hFFFF_FFFF);
    regRead(8'h30, d); check("R11", d, 32'h0);
    regRead(8'h20, d); check("R11", d, 32'h0);
    regRead(8'h24, d); check("R11", d, 32'h1);
    regRead(8'h28, d); check("R11", d, BASE + 32'(PAGES - 1) * 4096);

    // R10 unmap page 2
    regWrite(8'h28, BASE + 2 * 4096);
    regWrite(8'h2C, 32'h0);
    lookup("R10", BASE + 2 * 4096 + 32'h10, 1'b0, 32'h0);
    lookup("R10", BASE + 4 * 4096 + 32'h10, 1'b1, physOf(expTbl[4], BASE + 4 * 4096 + 32'h10));

    // R2 disable again
    regWrite(8'h24, 32'hFFFF_FFFE);
    regRead(8'h24, d); check("R2", d, 32'h0);
    lookup("R8", BASE + 4 * 4096, 1'b0, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule